// File: doc/BRIEF.md
# Host-to-SPI Flash Auto-Increment Write Bridge

This block sits between a host bus front end and a serial flash device. The host issues single-byte memory writes, each with a 24-bit address and one data byte. The bridge turns each write into an auto-address-increment program transfer on a mode-0 SPI link. It drives chip select, serial clock and serial data out. The program opcode is fixed by a parameter.

The bridge remembers whether the next write opens a new program sequence. A write that opens a sequence sends the opcode, then the three address bytes with the high byte first, then the data byte. Each later write in the same sequence sends only the opcode and the data byte, because the flash advances its own address. Three events make the next write a sequence opener again: the enable input goes low, a soft sequencer reset is pulsed, or another command (such as a read) is reported to have used the flash link.

While a transfer runs, the bridge holds a long-wait indication to the host. When the frame has left the chip it gives a one-cycle ready pulse, followed one cycle later by a one-cycle turnaround pulse. Only one transfer is in flight at a time.

Top module: `aai_wr_bridge`

## Requirements
- R1: A write that opens a sequence produces a 40-bit frame: the opcode byte, then address bits 23:16, 15:8 and 7:0, then the data byte, each byte sent most-significant bit first. For example, opcode 0xAF, address 0x064A70 and data 0x01 give the bytes AF 06 4A 70 01.
- R2: Each later write in the same sequence produces a 16-bit frame made of the opcode byte followed by the data byte, with no address.
- R3: The serial clock follows SPI mode 0. It idles low and is low whenever chip select is high. Data out changes only while the clock is low. One bit lasts SCK_DIV system clock cycles (4 by default).
- R4: Chip select (active low) stays low for the whole frame. It stays high for at least one system clock cycle between two frames.
- R5: From the cycle after a write is accepted until the frame ends, host_wait is high. host_ready then pulses for one cycle after chip select has risen, and host_tar pulses for one cycle in the cycle after host_ready.
- R6: xfer_busy rises when a frame is loaded. It falls in the same cycle in which chip select rises after the last bit.
- R7: A write request with host_byte low (not a single-byte access) is ignored: no wait, no ready and no frame.
- R8: While cfg_en is low or cfg_dummy is high, write requests are ignored: no wait, no ready and no frame. Clearing cfg_en makes the next serviced write open a new sequence.
- R9: A one-cycle pulse on cfg_sres makes the next write open a new sequence.
- R10: A one-cycle pulse on other_cmd makes the next write open a new sequence.
- R11: A write request that arrives while a transfer is in progress is ignored. Exactly one frame results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Auto-increment program mode enable |
| cfg_dummy | input | 1 | Dummy-cycle option; writes are refused while high |
| cfg_sres | input | 1 | Soft sequencer reset pulse |
| other_cmd | input | 1 | Pulse: another command used the flash link |
| host_req | input | 1 | Write request strobe |
| host_byte | input | 1 | Request is a single-byte access |
| host_addr | input | 24 | Write address |
| host_data | input | 8 | Write data byte |
| host_wait | output | 1 | Long wait to the host while a transfer runs |
| host_ready | output | 1 | One-cycle completion pulse |
| host_tar | output | 1 | One-cycle turnaround pulse after ready |
| xfer_busy | output | 1 | Frame loaded and not yet fully shifted |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
The bench decodes every frame from the serial pins and checks three cases: the address byte order within the 40-bit opener, the shortening to 16 bits on a continuing write, and the return to the long frame after each of the three reset events. A design that dropped one of those events would send a 16-bit frame without an address, and the flash would program the wrong location. Requests under every refusal condition (not enabled, dummy option on, wide access, already busy) must leave the pins and the handshake silent. A bridge that accepted them would start a second frame or give a ready pulse that was never earned. The bench also measures the bit period and watches when ready and turnaround appear relative to the chip-select release, which would catch a ready pulse that came before the last bit had gone out.

// File: rtl/aai_pkg.sv
package aai_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_XFER,
    SQ_RDY,
    SQ_TAR
  } seq_state_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_GAP
  } sh_state_t;

endpackage

// File: rtl/aai_frame_buf.sv
module aai_frame_buf #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter logic [OP_W-1:0] PROG_OP = 8'hAF,
  localparam int FR_W   = OP_W + ADDR_W + DATA_W,
  localparam int BITS_W = $clog2(FR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              first,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              shift,
  output logic              msb,
  output logic [BITS_W-1:0] nbits
);

  localparam int SHORT_W = OP_W + DATA_W;

  logic [FR_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (load) begin
      if (first) sreg <= {PROG_OP, addr, data};
      else       sreg <= {PROG_OP, data, {ADDR_W{1'b0}}};
    end else if (shift) begin
      sreg <= {sreg[FR_W-2:0], 1'b0};
    end
  end

  assign msb   = sreg[FR_W-1];
  assign nbits = first ? BITS_W'(FR_W) : BITS_W'(SHORT_W);

endmodule

// File: rtl/aai_spi_shift.sv
module aai_spi_shift
  import aai_pkg::*;
#(
  parameter int SCK_DIV = 4,
  parameter int CS_GAP  = 2,
  parameter int BITS_W  = 6,
  localparam int HALF   = SCK_DIV / 2,
  localparam int CNT_W  = (HALF > CS_GAP) ? $clog2(HALF + 1) : $clog2(CS_GAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BITS_W-1:0] nbits,
  output logic              idle,
  output logic              shift,
  output logic              last,
  output logic              sck,
  output logic              cs_n
);

  sh_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [BITS_W-1:0] left;
  logic              half_end;
  logic              gap_end;

  assign half_end = (cnt == CNT_W'(HALF - 1));
  assign gap_end  = (cnt == CNT_W'(CS_GAP - 1));
  assign idle     = (st == SH_IDLE);
  assign shift    = (st == SH_HIGH) && half_end && (left != BITS_W'(1));
  assign last     = (st == SH_HIGH) && half_end && (left == BITS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SH_IDLE;
      cnt  <= '0;
      left <= '0;
      sck  <= 1'b0;
      cs_n <= 1'b1;
    end else begin
      case (st)
        SH_IDLE: begin
          cnt <= '0;
          if (start) begin
            cs_n <= 1'b0;
            left <= nbits;
            st   <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (half_end) begin
            cnt <= '0;
            sck <= 1'b1;
            st  <= SH_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SH_HIGH: begin
          if (half_end) begin
            cnt <= '0;
            sck <= 1'b0;
            if (left == BITS_W'(1)) begin
              cs_n <= 1'b1;
              st   <= SH_GAP;
            end else begin
              left <= left - 1'b1;
              st   <= SH_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (gap_end) begin
            cnt <= '0;
            st  <= SH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/aai_seq.sv
module aai_seq
  import aai_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_dummy,
  input  logic              cfg_sres,
  input  logic              other_cmd,
  input  logic              host_req,
  input  logic              host_byte,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              sh_idle,
  input  logic              sh_last,
  output logic              load,
  output logic              first,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              wait_o,
  output logic              ready_o,
  output logic              tar_o,
  output logic              busy_o
);

  seq_state_t st;
  logic       accept;
  logic       restart;

  assign accept  = (st == SQ_IDLE) && host_req && host_byte && cfg_en && !cfg_dummy;
  assign restart = !cfg_en || cfg_sres || other_cmd;
  assign load    = (st == SQ_LOAD) && sh_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      first     <= 1'b1;
      hold_addr <= '0;
      hold_data <= '0;
      wait_o    <= 1'b0;
      ready_o   <= 1'b0;
      tar_o     <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      tar_o   <= 1'b0;
      if (restart)   first <= 1'b1;
      else if (load) first <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (accept) begin
            hold_addr <= host_addr;
            hold_data <= host_data;
            wait_o    <= 1'b1;
            st        <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          if (load) begin
            busy_o <= 1'b1;
            st     <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (sh_last) begin
            busy_o <= 1'b0;
            st     <= SQ_RDY;
          end
        end
        SQ_RDY: begin
          wait_o  <= 1'b0;
          ready_o <= 1'b1;
          st      <= SQ_TAR;
        end
        default: begin
          tar_o <= 1'b1;
          st    <= SQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/aai_wr_bridge.sv
module aai_wr_bridge #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int OP_W    = 8,
  parameter logic [OP_W-1:0] PROG_OP = 8'hAF,
  parameter int SCK_DIV = 4,
  parameter int CS_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_dummy,
  input  logic              cfg_sres,
  input  logic              other_cmd,
  input  logic              host_req,
  input  logic              host_byte,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_wait,
  output logic              host_ready,
  output logic              host_tar,
  output logic              xfer_busy,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi
);

  localparam int FR_W   = OP_W + ADDR_W + DATA_W;
  localparam int BITS_W = $clog2(FR_W + 1);

  logic              load;
  logic              first;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              sh_idle;
  logic              sh_shift;
  logic              sh_last;
  logic [BITS_W-1:0] nbits;

  aai_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_dummy (cfg_dummy),
    .cfg_sres  (cfg_sres),
    .other_cmd (other_cmd),
    .host_req  (host_req),
    .host_byte (host_byte),
    .host_addr (host_addr),
    .host_data (host_data),
    .sh_idle   (sh_idle),
    .sh_last   (sh_last),
    .load      (load),
    .first     (first),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .wait_o    (host_wait),
    .ready_o   (host_ready),
    .tar_o     (host_tar),
    .busy_o    (xfer_busy)
  );

  aai_frame_buf #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_OP(PROG_OP)
  ) u_buf (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .first (first),
    .addr  (hold_addr),
    .data  (hold_data),
    .shift (sh_shift),
    .msb   (spi_mosi),
    .nbits (nbits)
  );

  aai_spi_shift #(.SCK_DIV(SCK_DIV), .CS_GAP(CS_GAP), .BITS_W(BITS_W)) u_sh (
    .clk   (clk),
    .rst   (rst),
    .start (load),
    .nbits (nbits),
    .idle  (sh_idle),
    .shift (sh_shift),
    .last  (sh_last),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n)
  );

endmodule

// File: rtl/aai_wr_bridge_chk.sv
module aai_wr_bridge_chk (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic cfg_dummy,
  input logic host_req,
  input logic host_byte,
  input logic host_wait,
  input logic host_ready,
  input logic host_tar,
  input logic xfer_busy,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);  // R3

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));  // R3

  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> spi_cs_n);  // R4

  AST_READY_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (spi_cs_n && !host_wait && !xfer_busy));  // R5

  AST_TAR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> (host_tar && !host_ready));  // R5

  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_busy) |-> $rose(spi_cs_n));  // R6

  AST_ACCEPT_RULES: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wait) |-> $past(cfg_en && !cfg_dummy && host_req && host_byte));  // R8

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> host_wait);  // R11

endmodule

bind aai_wr_bridge aai_wr_bridge_chk u_chk (.*);

// File: tb/aai_wr_bridge_bench.sv
module aai_wr_bridge_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic        cfg_dummy = 1'b0;
  logic        cfg_sres = 1'b0;
  logic        other_cmd = 1'b0;
  logic        host_req = 1'b0;
  logic        host_byte = 1'b1;
  logic [23:0] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic        host_wait, host_ready, host_tar, xfer_busy;
  logic        spi_cs_n, spi_sck, spi_mosi;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  aai_wr_bridge u_aai_wr_bridge (.*);

  // serial-side monitor, sampled away from the active edge
  logic [63:0] mon_bits = '0;
  int          mon_len  = 0;
  int          cur_len  = 0;
  logic [63:0] cur_bits = '0;
  int          frames   = 0;
  int          last_rise = -1;
  int          bad_period = 0;
  logic        p_sck = 1'b0, p_cs = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (p_cs && !spi_cs_n) begin
        cur_len  = 0;
        cur_bits = '0;
        last_rise = -1;
      end
      if (!p_sck && spi_sck) begin
        cur_bits = {cur_bits[62:0], spi_mosi};
        cur_len++;
        if (last_rise >= 0 && (cyc - last_rise) != 4) bad_period++;
        last_rise = cyc;
      end
      if (!p_cs && spi_cs_n) begin
        mon_bits = cur_bits;
        mon_len  = cur_len;
        frames++;
      end
    end
    p_sck = spi_sck;
    p_cs  = spi_cs_n;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  task automatic pulse_req(input logic [23:0] a, input logic [7:0] d, input logic byt);
    @(negedge clk);
    host_req = 1'b1; host_addr = a; host_data = d; host_byte = byt;
    @(negedge clk);
    host_req = 1'b0; host_byte = 1'b1;
  endtask

  // serviced write: checks frame contents, wait, ready and turnaround
  task automatic do_write(input logic [23:0] a, input logic [7:0] d, input bit opener, input string tag);
    int  n;
    bit  saw_wait;
    bit  saw_busy;
    int  f0;
    logic [63:0] exp;
    f0 = frames;
    pulse_req(a, d, 1'b1);
    saw_wait = host_wait;
    saw_busy = 1'b0;
    n = 0;
    while (!host_ready && n < 2000) begin
      if (xfer_busy) saw_busy = 1'b1;
      if (!spi_cs_n && !host_wait) saw_wait = 1'b0;
      @(negedge clk);
      n++;
    end
    check(host_ready, {tag, " R5 ready pulse"}, 64'(host_ready), 1);
    check(saw_wait, {tag, " R5 wait held during frame"}, 64'(saw_wait), 1);
    check(saw_busy && !xfer_busy, {tag, " R6 busy during frame only"}, 64'(xfer_busy), 0);
    check(spi_cs_n && frames == f0 + 1, {tag, " R4 frame closed before ready"}, 64'(frames - f0), 1);
    exp = opener ? {24'h0, 8'hAF, a, d} : {48'h0, 8'hAF, d};
    check(mon_len == (opener ? 40 : 16), {tag, opener ? " R1 frame length" : " R2 frame length"},
          64'(mon_len), opener ? 40 : 16);
    check(mon_bits == exp, {tag, opener ? " R1 frame bits" : " R2 frame bits"}, mon_bits, exp);
    @(negedge clk);
    check(host_tar && !host_ready, {tag, " R5 turnaround after ready"}, 64'(host_tar), 1);
    @(negedge clk);
    check(!host_tar, {tag, " R5 turnaround one cycle"}, 64'(host_tar), 0);
  endtask

  task automatic expect_ignored(input logic [23:0] a, input logic [7:0] d, input logic byt, input string tag);
    int f0;
    bit any;
    f0 = frames;
    any = 1'b0;
    pulse_req(a, d, byt);
    for (int i = 0; i < 300; i++) begin
      if (host_wait || host_ready || !spi_cs_n) any = 1'b1;
      @(negedge clk);
    end
    check(!any && frames == f0, {tag, " request ignored"}, 64'(frames - f0), 0);
  endtask

  task automatic t_reset();
    check(spi_cs_n && !spi_sck && !host_wait && !host_ready && !xfer_busy,
          "R3 R4 reset idle outputs", {59'h0, spi_cs_n, spi_sck, host_wait, host_ready, xfer_busy}, 64'h10);
  endtask

  task automatic t_sequence();
    do_write(24'h064A70, 8'h01, 1'b1, "R1 opener");
    do_write(24'h064A71, 8'h5A, 1'b0, "R2 continue a");
    do_write(24'h064A72, 8'hC3, 1'b0, "R2 continue b");
    check(bad_period == 0, "R3 bit period", 64'(bad_period), 0);
  endtask

  task automatic t_refusals();
    expect_ignored(24'h111111, 8'h22, 1'b0, "R7 wide access");
    cfg_dummy = 1'b1;
    expect_ignored(24'h121212, 8'h33, 1'b1, "R8 dummy option");
    cfg_dummy = 1'b0;
    cfg_en = 1'b0;
    expect_ignored(24'h131313, 8'h44, 1'b1, "R8 disabled");
    cfg_en = 1'b1;
    do_write(24'hFEDCBA, 8'h99, 1'b1, "R8 reopen after disable");
  endtask

  task automatic t_restarts();
    do_write(24'h000010, 8'h11, 1'b0, "R9 before sres");
    @(negedge clk); cfg_sres = 1'b1; @(negedge clk); cfg_sres = 1'b0;
    do_write(24'h800000, 8'h7E, 1'b1, "R9 after sres");
    do_write(24'h800001, 8'h80, 1'b0, "R10 before other");
    @(negedge clk); other_cmd = 1'b1; @(negedge clk); other_cmd = 1'b0;
    do_write(24'h0000FF, 8'hE1, 1'b1, "R10 after other cmd");
  endtask

  task automatic t_busy_req();
    int f0;
    int n;
    f0 = frames;
    pulse_req(24'h0000FF, 8'h3C, 1'b1);
    repeat (20) @(negedge clk);
    pulse_req(24'h555555, 8'hA5, 1'b1);
    n = 0;
    while (!host_ready && n < 2000) begin @(negedge clk); n++; end
    check(mon_bits == {48'h0, 8'hAF, 8'h3C} && mon_len == 16, "R11 first frame kept",
          mon_bits, {48'h0, 8'hAF, 8'h3C});
    repeat (300) @(negedge clk);
    check(frames == f0 + 1, "R11 extra request ignored", 64'(frames - f0), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg_en = 1'b1;
    t_sequence();
    t_refusals();
    t_restarts();
    t_busy_req();
    finish_run();
  end

endmodule